// File: doc/BRIEF.md
# Region Lock Write Protection Controller

This block is the write gate that sits behind a serial memory front end. The front end decodes the serial stream and passes decoded strobes to this block. One strobe marks an enable command, one marks a disable command, one marks every completed byte, one marks a memory write ready to commit together with its address, and one marks a lock byte. The block answers whether the nonvolatile write may start. It also keeps the state that this decision depends on: a write-enable latch, a three-bit region-lock code in the status byte, a cancel flag driven by the protect pin, and a self-timed busy timer that stands in for the array's programming time.

The lock code picks one protected window of the address space: a quarter, the lower half, the first page or the last page. Protected addresses stay readable, but the gate refuses every write aimed at them. The lock code is modelled as a nonvolatile flop. It is cleared only by the power-up reset and keeps its value through the soft reset.

Top module: `region_wp_guard`

## Requirements
- R1: After the power-up reset `status` reads 0x00, `busy` is low and a write request without a prior enable command is refused (`wr_grant` low).
- R2: An enable command followed by CS rising arms the latch. A following write request to an unprotected address is granted in the same cycle as `wr_stb`. The grant consumes the latch, so a second request without a new enable command is refused.
- R3: If another byte is completed after the enable command and before CS rises, the enable command has no effect and the next write request is refused.
- R4: A disable command clears the write-enable latch, and a later write request is refused.
- R5: With lock code c stored in `status[2:0]`, a write to address a is refused exactly when a lies in the window for c. The windows are: 0 none, 1 0x000-0x0FF, 2 0x100-0x1FF, 3 0x200-0x2FF, 4 0x300-0x3FF, 5 0x000-0x1FF, 6 0x000-0x00F, 7 0x3F0-0x3FF.
- R6: A write refused because of the lock leaves the latch set. A following request to an unprotected address is then granted without a new enable command.
- R7: While `wp_n` is low, write requests are refused and a lock update does not change the lock code. The latch is kept, so a request after `wp_n` returns high is granted.
- R8: If `wp_n` falls while CS is low, the write requested at the end of that transfer is refused. The next transfer, which begins with CS falling, is unaffected. A write whose busy period has already started keeps running when `wp_n` falls.
- R9: Lock bytes received while CS is low are held pending, and the last one received wins. On CS rising, with the latch set, the pending byte is stored with bits 7:3 forced to zero. Without the latch, the lock code stays unchanged.
- R10: A granted write or lock update holds `busy` high for exactly BUSY_CYC cycles. During that time `status` reads 0xFF and every write request is refused without consuming the latch.
- R11: The soft reset clears the write-enable latch but keeps the lock code. The power-up reset sets the lock code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, synchronous, active low; clears all state including the lock code |
| rst_n | input | 1 | Soft reset, synchronous, active low; lock code survives |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write protect pin, low blocks nonvolatile writes |
| wren_stb | input | 1 | Enable command byte completed |
| wrdi_stb | input | 1 | Disable command byte completed |
| byte_stb | input | 1 | Any byte completed on the serial input |
| wr_stb | input | 1 | Memory write ready to commit |
| wr_addr | input | ADDR_W | Address of the write to commit |
| lock_stb | input | 1 | Lock byte received |
| lock_byte | input | 8 | Lock byte value |
| wr_grant | output | 1 | Write may proceed (combinational with wr_stb) |
| busy | output | 1 | Self-timed write in progress |
| status | output | 8 | Lock code byte, or 0xFF while busy |

## Verification
The hardest case to reach is the protect pin cancelling a transfer. The pin must fall while CS is low and recover before CS rises. The write request then arrives with the pin already high again and the latch still set, so only the stored cancel flag can refuse it. The bench builds this transfer by hand and then shows that the next transfer is granted. It also sweeps every lock code against one address in each of the 64 pages, and it replays an unprotected write after each lock refusal to show the latch survived.

// File: rtl/rl_pkg.sv
// Package rl_pkg
// Purpose : shared names for the region-lock codes.
// Assumes : a 3-bit lock code; window sizes are set by the users of the codes.
package rl_pkg;
    typedef enum logic [2:0] {
        LK_NONE  = 3'd0,
        LK_Q1    = 3'd1,
        LK_Q2    = 3'd2,
        LK_Q3    = 3'd3,
        LK_Q4    = 3'd4,
        LK_HALF  = 3'd5,
        LK_FIRST = 3'd6,
        LK_LAST  = 3'd7
    } lock_code_e;
endpackage

// File: rtl/rl_region.sv
// Module  rl_region
// Purpose : combinational test of whether an address lies in the window
//           that the lock code selects.
// Assumes : ADDR_W >= PAGE_W + 2; every window is page aligned, so a page
//           write is judged fully by its start address.
module rl_region
    import rl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int PAGE_W = 4
) (
    input  logic [2:0]        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int PN_W = ADDR_W - PAGE_W;

    logic [1:0]      quad;
    logic [PN_W-1:0] page;

    assign quad = addr[ADDR_W-1 -: 2];
    assign page = addr[ADDR_W-1 : PAGE_W];

    // decode the lock code into a window hit
    always_comb begin
        unique case (lock_code_e'(code))
            LK_NONE:  hit = 1'b0;
            LK_Q1:    hit = (quad == 2'd0);
            LK_Q2:    hit = (quad == 2'd1);
            LK_Q3:    hit = (quad == 2'd2);
            LK_Q4:    hit = (quad == 2'd3);
            LK_HALF:  hit = ~addr[ADDR_W-1];
            LK_FIRST: hit = (page == '0);
            LK_LAST:  hit = (page == '1);
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/rl_wel.sv
// Module  rl_wel
// Purpose : write-enable latch. An enable command arms it, and it is set
//           only if CS rises before any further byte is completed.
// Assumes : strobes are single-cycle pulses; cs_rise is a one-cycle pulse.
module rl_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_rise,
    input  logic wren_stb,
    input  logic wrdi_stb,
    input  logic byte_stb,
    input  logic consume,
    output logic wel
);
    logic arm;

    // track whether the enable command was the last byte of the transfer
    always_ff @(posedge clk) begin
        if (!rst_n)        arm <= 1'b0;
        else if (cs_rise)  arm <= 1'b0;
        else if (wren_stb) arm <= 1'b1;
        else if (byte_stb) arm <= 1'b0;
    end

    // latch: clear on disable or on a started write, set on qualified CS rise
    always_ff @(posedge clk) begin
        if (!rst_n)                  wel <= 1'b0;
        else if (wrdi_stb || consume) wel <= 1'b0;
        else if (cs_rise && arm)     wel <= 1'b1;
    end

    // R4
    wrdi_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi_stb |=> !wel);

    // R3
    wel_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(cs_rise) && $past(arm));
endmodule

// File: rtl/rl_busy.sv
// Module  rl_busy
// Purpose : self-timed write timer; busy stays high for CYC cycles per load.
// Assumes : load is only raised while idle (the caller gates grants on busy).
module rl_busy #(
    parameter int CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // load the count on a start, then run down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (load)      cnt <= CW'(CYC);
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R10
    busy_countdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/region_wp_guard.sv
// Module  region_wp_guard
// Purpose : decides whether a nonvolatile memory write or lock update may
//           start. It combines the write-enable latch, the region lock, the
//           protect pin, the per-transfer cancel flag and the busy timer.
// Assumes : the serial front end delivers decoded single-cycle strobes;
//           wr_stb is issued once CS has risen at a valid byte boundary.
module region_wp_guard #(
    parameter int ADDR_W   = 10,
    parameter int PAGE_W   = 4,
    parameter int BUSY_CYC = 64
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wp_n,
    input  logic              wren_stb,
    input  logic              wrdi_stb,
    input  logic              byte_stb,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              lock_stb,
    input  logic [7:0]        lock_byte,
    output logic              wr_grant,
    output logic              busy,
    output logic [7:0]        status
);
    localparam logic [7:0] LOCK_MASK = 8'h07;

    logic       soft_n;
    logic       cs_q, wp_q;
    logic       cs_rise, cs_fall;
    logic       cancel;
    logic       lock_pend;
    logic [7:0] pend_byte;
    logic [7:0] stat_q;
    logic       wel, hit, ok_base, lock_go, start;

    assign soft_n  = por_n & rst_n;
    assign cs_rise = cs_n & ~cs_q;
    assign cs_fall = ~cs_n & cs_q;

    // edge history of CS and the protect pin
    always_ff @(posedge clk) begin
        if (!soft_n) begin
            cs_q <= 1'b1;
            wp_q <= 1'b1;
        end else begin
            cs_q <= cs_n;
            wp_q <= wp_n;
        end
    end

    // protect pin falling inside a transfer cancels that transfer's write
    always_ff @(posedge clk) begin
        if (!soft_n)                       cancel <= 1'b0;
        else if (cs_fall)                  cancel <= 1'b0;
        else if (!cs_n && wp_q && !wp_n)   cancel <= 1'b1;
    end

    // hold the latest lock byte of the transfer, masked, until CS rises
    always_ff @(posedge clk) begin
        if (!soft_n) begin
            lock_pend <= 1'b0;
            pend_byte <= '0;
        end else if (cs_rise) begin
            lock_pend <= 1'b0;
        end else if (lock_stb) begin
            lock_pend <= 1'b1;
            pend_byte <= lock_byte & LOCK_MASK;
        end
    end

    // nonvolatile lock field: only the power-up reset clears it
    always_ff @(posedge clk) begin
        if (!por_n)       stat_q <= '0;
        else if (lock_go) stat_q <= pend_byte;
    end

    rl_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .code (stat_q[2:0]),
        .addr (wr_addr),
        .hit  (hit)
    );

    rl_wel u_wel (
        .clk      (clk),
        .rst_n    (soft_n),
        .cs_rise  (cs_rise),
        .wren_stb (wren_stb),
        .wrdi_stb (wrdi_stb),
        .byte_stb (byte_stb),
        .consume  (start),
        .wel      (wel)
    );

    rl_busy #(.CYC(BUSY_CYC)) u_busy (
        .clk   (clk),
        .rst_n (soft_n),
        .load  (start),
        .busy  (busy)
    );

    assign ok_base  = wel & wp_n & ~busy & ~cancel;
    assign wr_grant = wr_stb & ok_base & ~hit;
    assign lock_go  = cs_rise & lock_pend & ok_base;
    assign start    = wr_grant | lock_go;
    assign status   = busy ? 8'hFF : stat_q;

    // R10
    grant_starts_busy_chk: assert property (@(posedge clk) disable iff (!soft_n)
        wr_grant |=> busy);

    // R2
    grant_consumes_chk: assert property (@(posedge clk) disable iff (!soft_n)
        wr_grant |=> !wel);

    // R9
    lock_only_on_cs_chk: assert property (@(posedge clk) disable iff (!soft_n)
        !cs_rise |=> $stable(stat_q));
endmodule

// File: tb/sim_region_wp_guard.sv
module sim_region_wp_guard;
    localparam int AW = 10;
    localparam int BC = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0, rst_n = 1'b1, cs_n = 1'b1, wp_n = 1'b1;
    logic wren_stb = 0, wrdi_stb = 0, byte_stb = 0, wr_stb = 0, lock_stb = 0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] lock_byte = '0;
    logic wr_grant, busy;
    logic [7:0] status;
    int total = 0, fails = 0;

    region_wp_guard #(.ADDR_W(AW), .PAGE_W(4), .BUSY_CYC(BC)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
        .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .byte_stb(byte_stb),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .lock_stb(lock_stb),
        .lock_byte(lock_byte), .wr_grant(wr_grant), .busy(busy), .status(status)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_locked(input int code, input int a);
        int lo, hi;
        lo = 1; hi = 0;
        if (code >= 1 && code <= 4) begin lo = (code - 1) * 256; hi = lo + 255; end
        else if (code == 5) begin lo = 0;    hi = 511;  end
        else if (code == 6) begin lo = 0;    hi = 15;   end
        else if (code == 7) begin lo = 1008; hi = 1023; end
        return (a >= lo) && (a <= hi);
    endfunction

    task automatic cmd_byte(input bit en, input bit dis);
        tick(); wren_stb = en; wrdi_stb = dis; byte_stb = 1;
        tick(); wren_stb = 0; wrdi_stb = 0; byte_stb = 0;
    endtask

    task automatic wren();
        tick(); cs_n = 0;
        cmd_byte(1, 0);
        cs_n = 1; tick();
    endtask

    task automatic wrdi();
        tick(); cs_n = 0;
        cmd_byte(0, 1);
        cs_n = 1; tick();
    endtask

    task automatic try_write(input int a, output bit g);
        tick(); cs_n = 0;
        tick(); cs_n = 1; wr_stb = 1; wr_addr = AW'(a);
        #1 g = wr_grant;
        tick(); wr_stb = 0;
    endtask

    task automatic idle();
        repeat (BC + 2) tick();
    endtask

    task automatic set_lock(input logic [7:0] b);
        tick(); cs_n = 0;
        tick(); lock_stb = 1; byte_stb = 1; lock_byte = b;
        tick(); lock_stb = 0; byte_stb = 0; cs_n = 1;
        tick();
    endtask

    initial begin
        #(20 * 150000);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        bit g;
        int ua;
        repeat (3) tick();
        por_n = 1; tick();

        // R1 reset state
        chk("R1 status", status, 8'h00);
        chk("R1 busy", busy, 0);
        try_write(0, g); chk("R1 no latch", g, 0);

        // R2 enable then grant, grant consumes latch
        wren(); try_write(16'h123, g); chk("R2 grant", g, 1);
        idle();
        try_write(16'h123, g); chk("R2 consumed", g, 0);

        // R10 exact busy length, status FF, busy blocks without consuming
        wren(); try_write(5, g); chk("R10 grant", g, 1);
        chk("R10 busy start", busy, 1);
        chk("R10 status busy", status, 8'hFF);
        repeat (BC - 1) tick(); chk("R10 busy last", busy, 1);
        tick(); chk("R10 busy end", busy, 0);
        wren(); try_write(6, g); chk("R10 grant2", g, 1);
        wren(); try_write(7, g); chk("R10 blocked", g, 0);
        idle();
        try_write(7, g); chk("R10 latch kept", g, 1);
        idle();

        // R3 extra byte after enable
        tick(); cs_n = 0; cmd_byte(1, 0); cmd_byte(0, 0); cs_n = 1; tick();
        try_write(9, g); chk("R3 ignored", g, 0);

        // R4 disable clears
        wren(); wrdi(); try_write(9, g); chk("R4 cleared", g, 0);

        // R7 protect pin low
        wren(); wp_n = 0;
        try_write(9, g); chk("R7 wr blocked", g, 0);
        set_lock(8'h03); idle(); chk("R7 lock blocked", status, 0);
        wp_n = 1; tick();
        try_write(9, g); chk("R7 latch kept", g, 1);
        idle();

        // R8 pin falls inside transfer cancels it
        wren();
        tick(); cs_n = 0;
        tick(); wp_n = 0;
        tick(); wp_n = 1;
        tick(); cs_n = 1; wr_stb = 1; wr_addr = 10'h40;
        #1 g = wr_grant;
        tick(); wr_stb = 0;
        chk("R8 cancelled", g, 0);
        try_write(10'h40, g); chk("R8 next ok", g, 1);
        tick(); cs_n = 0; wp_n = 0; tick();
        chk("R8 started runs", busy, 1);
        cs_n = 1; wp_n = 1; idle();
        chk("R8 finished", busy, 0);

        // R9 last lock byte wins, masked; no latch no change
        wren();
        tick(); cs_n = 0;
        tick(); lock_stb = 1; byte_stb = 1; lock_byte = 8'hF9;
        tick(); lock_byte = 8'hFE;
        tick(); lock_stb = 0; byte_stb = 0; cs_n = 1;
        tick(); chk("R9 busy status", status, 8'hFF);
        idle(); chk("R9 last wins masked", status, 8'h06);
        set_lock(8'h02); idle(); chk("R9 needs latch", status, 8'h06);

        // R5 / R6 sweep of every code against every page
        for (int c = 0; c < 8; c++) begin
            wren(); set_lock(8'(c)); idle();
            chk("R9 code stored", status, c);
            ua = exp_locked(c, 1023) ? 0 : 1023;
            for (int p = 0; p < 64; p++) begin
                int a;
                a = p * 16 + (p % 16);
                wren(); try_write(a, g);
                chk("R5 lock window", g, !exp_locked(c, a));
                if (g) idle();
                else begin
                    try_write(ua, g); chk("R6 latch kept", g, 1);
                    idle();
                end
            end
        end

        // R11 soft reset keeps lock, clears latch; power reset clears lock
        wren(); set_lock(8'h03); idle();
        wren();
        tick(); rst_n = 0; tick(); rst_n = 1; tick();
        chk("R11 lock kept", status, 3);
        try_write(10'h000, g); chk("R11 latch cleared", g, 0);
        tick(); por_n = 0; tick(); por_n = 1; tick();
        chk("R11 por clears", status, 0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule